// File: doc/BRIEF.md
# Channel-Parallel Convolution Multiply-Accumulate Engine

This engine produces one output pixel of a convolution layer with a 5x5 kernel. Each accepted beat carries `LANES` pixels and `LANES` weights. Each pixel comes from a different input channel and is paired with its own weight. All lanes are multiplied in the same cycle. A pipelined adder tree reduces the products to a single partial sum. A running accumulator then collects those partial sums across the beats that make up one output, which is `TAPS * N_IF / LANES` beats in normal use.

The upstream sequencer marks the first beat of an output, which reloads the accumulator, and the last beat, which releases the result. The full-precision sum is rounded half-up back to signed Q8.8 and clamped to the 16-bit range. When `LANES` equals the channel count and every beat is both first and last, the engine delivers one result per clock.

Top module: `conv_chan_mac`

## Requirements
- R1: Lane j occupies bits [16j+15:16j] of both `in_pix` and `in_wgt`, and every operand is a signed two's-complement Q8.8 value. A beat contributes the exact sum over all lanes of pixel times weight, taken as a raw Q16.16 integer.
- R2: A valid beat with `in_first` set discards any earlier running sum and loads its own contribution.
- R3: A valid beat without `in_first` adds its contribution to the running sum.
- R4: Every valid beat with `in_last` set yields exactly one cycle of `out_valid`. That cycle is the clock edge `$clog2(LANES)+2` edges after the edge that accepts the beat. No other cycle asserts `out_valid`.
- R5: While reset is active and after it is released, `out_valid` and `out_data` read 0 until the first result arrives.
- R6: The result is floor((S + 128) / 256), where S is the raw Q16.16 running sum. Exact halves therefore round toward positive infinity.
- R7: Results above 32767 are clamped to 32767, and results below -32768 are clamped to -32768.
- R8: A beat carrying both markers is a complete output on its own. Such beats may arrive back to back, each yielding its own result on successive cycles.
- R9: When `in_valid` is low, the pixel, weight and marker inputs have no effect on the running sum or on the outputs.
- R10: `out_data` holds the most recent result for as long as `out_valid` stays low.
- R11: The accumulator holds `TAPS * N_IF` full-scale products without wrapping. A group of all-positive or all-negative full-scale products therefore saturates toward the correct sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_first | input | 1 | Beat starts a new output (reload accumulator) |
| in_last | input | 1 | Beat ends the output (emit result) |
| in_pix | input | LANES*DATA_W | Packed per-lane pixels, Q8.8 |
| in_wgt | input | LANES*DATA_W | Packed per-lane weights, Q8.8 |
| out_valid | output | 1 | Result qualifier, one cycle per output |
| out_data | output | DATA_W | Rounded, saturated Q8.8 result |

## Verification
The bench builds the engine with four lanes, eight channels and the 25-tap kernel, which gives a two-level adder tree and a four-cycle latency. With only four lanes, the bench can sweep every sum residue from -1024 to 1023 through single-beat outputs. This exercises each rounding case and full back-to-back throughput. The same configuration keeps a full 50-beat output short enough to run many random groups, reload and idle-gap cases, and full-scale saturation groups of both signs against a 64-bit arithmetic model.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;

   // Control flags that travel alongside each beat through the pipeline.
   typedef struct packed {
      logic valid;
      logic first;
      logic last;
   } beat_tag_t;

   // Number of pipelined levels needed to reduce a given lane count.
   function automatic int tree_levels(input int lanes);
      int lv;
      lv = 0;
      while ((1 << lv) < lanes) lv++;
      return lv;
   endfunction

endpackage

// File: rtl/mac_mult_row.sv
module mac_mult_row
   import conv_mac_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  beat_tag_t                   tag_in,
   input  logic [LANES*DATA_W-1:0]     pix,
   input  logic [LANES*DATA_W-1:0]     wgt,
   output beat_tag_t                   tag_out,
   output logic [LANES*2*DATA_W-1:0]   prod_flat
);

   localparam int PROD_W = 2 * DATA_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [DATA_W-1:0] op_a;
      logic signed [DATA_W-1:0] op_b;
      logic signed [PROD_W-1:0] prod_q;

      assign op_a = pix[g*DATA_W +: DATA_W];
      assign op_b = wgt[g*DATA_W +: DATA_W];

      always_ff @(posedge clk) begin
         prod_q <= op_a * op_b;
      end

      assign prod_flat[g*PROD_W +: PROD_W] = prod_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_out <= '0;
      else        tag_out <= tag_in;
   end

endmodule

// File: rtl/mac_adder_tree.sv
module mac_adder_tree
   import conv_mac_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IN_W  = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  beat_tag_t                           tag_in,
   input  logic [LANES*IN_W-1:0]               leaf_flat,
   output beat_tag_t                           tag_out,
   output logic [IN_W+tree_levels(LANES)-1:0]  root
);

   localparam int LVLS  = tree_levels(LANES);
   localparam int PAD   = 1 << LVLS;
   localparam int OUT_W = IN_W + LVLS;

   if (LVLS == 0) begin : g_single
      // One lane: nothing to reduce, no extra pipeline stage.
      assign root    = leaf_flat;
      assign tag_out = tag_in;
   end else begin : g_tree
      logic signed [OUT_W-1:0] leaf_ext [PAD];
      logic signed [OUT_W-1:0] node_q   [1:PAD-1];
      beat_tag_t               tag_pipe [LVLS];

      // Sign-extend real lanes, pad missing lanes with zero.
      for (genvar j = 0; j < PAD; j++) begin : g_leaf
         if (j < LANES) begin : g_real
            assign leaf_ext[j] = {{LVLS{leaf_flat[j*IN_W+IN_W-1]}},
                                  leaf_flat[j*IN_W +: IN_W]};
         end else begin : g_zero
            assign leaf_ext[j] = '0;
         end
      end

      // Heap-ordered nodes: node i sums children 2i and 2i+1.
      for (genvar i = 1; i < PAD; i++) begin : g_node
         logic signed [OUT_W-1:0] lhs;
         logic signed [OUT_W-1:0] rhs;
         if (2*i >= PAD) begin : g_from_leaf
            assign lhs = leaf_ext[2*i-PAD];
            assign rhs = leaf_ext[2*i+1-PAD];
         end else begin : g_from_node
            assign lhs = node_q[2*i];
            assign rhs = node_q[2*i+1];
         end
         always_ff @(posedge clk) begin
            node_q[i] <= lhs + rhs;
         end
      end

      // Flags take one stage per level so they stay aligned with the sum.
      for (genvar s = 0; s < LVLS; s++) begin : g_tag
         beat_tag_t tag_src;
         if (s == 0) begin : g_head
            assign tag_src = tag_in;
         end else begin : g_body
            assign tag_src = tag_pipe[s-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tag_pipe[s] <= '0;
            else        tag_pipe[s] <= tag_src;
         end
      end

      assign root    = node_q[1];
      assign tag_out = tag_pipe[LVLS-1];
   end

endmodule

// File: rtl/mac_requant.sv
module mac_requant #(
   parameter int ACC_W  = 41,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 8
) (
   input  logic [ACC_W-1:0]  wide,
   output logic [DATA_W-1:0] narrow
);

   localparam logic signed [ACC_W-1:0] HALF =
      {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] QMAX =
      {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] QMIN =
      {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] shifted;

   always_comb begin
      biased  = $signed(wide) + HALF;
      shifted = biased >>> FRAC_W;
      if (shifted > QMAX)      narrow = QMAX[DATA_W-1:0];
      else if (shifted < QMIN) narrow = QMIN[DATA_W-1:0];
      else                     narrow = shifted[DATA_W-1:0];
   end

endmodule

// File: rtl/mac_group_accum.sv
module mac_group_accum
   import conv_mac_pkg::*;
#(
   parameter int IN_W   = 34,
   parameter int ACC_W  = 41,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  beat_tag_t         tag_in,
   input  logic [IN_W-1:0]   part_sum,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data
);

   logic signed [ACC_W-1:0] part_ext;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_nxt;
   logic [DATA_W-1:0]       quant;

   assign part_ext = {{(ACC_W-IN_W){part_sum[IN_W-1]}}, part_sum};

   always_comb begin
      if (tag_in.first) acc_nxt = part_ext;
      else              acc_nxt = acc_q + part_ext;
   end

   mac_requant #(
      .ACC_W  (ACC_W),
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W)
   ) u_requant (
      .wide   (acc_nxt),
      .narrow (quant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= tag_in.valid && tag_in.last;
         if (tag_in.valid) acc_q <= acc_nxt;
         if (tag_in.valid && tag_in.last) res_data <= quant;
      end
   end

endmodule

// File: rtl/conv_chan_mac.sv
module conv_chan_mac
   import conv_mac_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int N_IF   = 8,
   parameter int TAPS   = 25,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_first,
   input  logic                    in_last,
   input  logic [LANES*DATA_W-1:0] in_pix,
   input  logic [LANES*DATA_W-1:0] in_wgt,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data
);

   localparam int PROD_W    = 2 * DATA_W;
   localparam int TREE_LVLS = tree_levels(LANES);
   localparam int TREE_W    = PROD_W + TREE_LVLS;
   localparam int ACC_W     = PROD_W + $clog2(TAPS * N_IF) + 1;
   localparam int LATENCY   = TREE_LVLS + 2;

   // Elaboration-time parameter checks.
   if (LANES < 1) begin : g_chk_lanes
      $error("conv_chan_mac: LANES must be at least 1");
   end
   if (LANES > N_IF) begin : g_chk_unroll
      $error("conv_chan_mac: LANES may not exceed N_IF");
   end
   if (FRAC_W < 1 || FRAC_W >= DATA_W) begin : g_chk_frac
      $error("conv_chan_mac: FRAC_W must lie in 1..DATA_W-1");
   end
   if (TREE_W > ACC_W) begin : g_chk_acc
      $error("conv_chan_mac: accumulator narrower than tree output");
   end
   if (LATENCY < 2) begin : g_chk_lat
      $error("conv_chan_mac: latency derivation broken");
   end

   beat_tag_t                 tag_in;
   beat_tag_t                 tag_prod;
   beat_tag_t                 tag_sum;
   logic [LANES*PROD_W-1:0]   prod_flat;
   logic [TREE_W-1:0]         tree_root;

   assign tag_in = '{valid: in_valid, first: in_first, last: in_last};

   mac_mult_row #(
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .tag_in    (tag_in),
      .pix       (in_pix),
      .wgt       (in_wgt),
      .tag_out   (tag_prod),
      .prod_flat (prod_flat)
   );

   mac_adder_tree #(
      .LANES (LANES),
      .IN_W  (PROD_W)
   ) u_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .tag_in    (tag_prod),
      .leaf_flat (prod_flat),
      .tag_out   (tag_sum),
      .root      (tree_root)
   );

   mac_group_accum #(
      .IN_W   (TREE_W),
      .ACC_W  (ACC_W),
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W)
   ) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .tag_in    (tag_sum),
      .part_sum  (tree_root),
      .res_valid (out_valid),
      .res_data  (out_data)
   );

endmodule

// File: rtl/conv_chan_mac_chk.sv
module conv_chan_mac_chk
   import conv_mac_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_last,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);

   localparam int LAT = tree_levels(LANES) + 2;

   // Cycles since reset release, saturating, so $past never reaches before it.
   logic [7:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != '1)  since_rst <= since_rst + 8'd1;
   end

   // R4
   out_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((since_rst >= LAT) && $past(in_valid && in_last, LAT)));

   // R4
   cause_has_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst >= LAT) && $past(in_valid && in_last, LAT)) |-> out_valid);

   // R10
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

   // R5
   valid_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(out_valid));

endmodule

bind conv_chan_mac conv_chan_mac_chk #(
   .LANES  (LANES),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/conv_chan_mac_test.sv
`timescale 1ns/1ps
module conv_chan_mac_test;

   localparam int LANES  = 4;
   localparam int N_IF   = 8;
   localparam int TAPS   = 25;
   localparam int DATA_W = 16;
   localparam int BUS    = LANES * DATA_W;
   localparam int LAT    = 4;              // two tree levels + product + accumulate
   localparam int BEATS  = TAPS * N_IF / LANES;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           in_valid, in_first, in_last;
   logic [BUS-1:0] in_pix, in_wgt;
   logic           out_valid;
   logic [DATA_W-1:0] out_data;

   int     n_tests = 0;
   int     n_fail  = 0;
   bit     done    = 1'b0;
   longint model_acc = 0;
   int     exp_q[$];
   string  tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   conv_chan_mac #(
      .LANES (LANES), .N_IF (N_IF), .TAPS (TAPS), .DATA_W (DATA_W), .FRAC_W (8)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_first (in_first), .in_last (in_last),
      .in_pix (in_pix), .in_wgt (in_wgt),
      .out_valid (out_valid), .out_data (out_data)
   );

   function automatic int quant(input longint s);
      longint r;
      r = (s + 128) >>> 8;
      if (r > 32767)  return 32767;
      if (r < -32768) return -32768;
      return int'(r);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One accepted beat; model updated from the requirements.
   task automatic beat(input bit f, input bit l, input logic [BUS-1:0] p,
                       input logic [BUS-1:0] w, input string tag);
      longint s;
      s = 0;
      for (int j = 0; j < LANES; j++)
         s += longint'($signed(p[j*DATA_W +: DATA_W])) * longint'($signed(w[j*DATA_W +: DATA_W]));
      model_acc = f ? s : model_acc + s;
      if (l) begin
         exp_q.push_back(quant(model_acc));
         tag_q.push_back(tag);
      end
      in_valid = 1'b1; in_first = f; in_last = l; in_pix = p; in_wgt = w;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Idle cycles with garbage on every qualified input (R9).
   task automatic idle(input int n, input bit quiet);
      for (int k = 0; k < n; k++) begin
         in_valid = 1'b0;
         in_first = 1'($urandom);
         in_last  = 1'($urandom);
         in_pix   = {$urandom, $urandom};
         in_wgt   = {$urandom, $urandom};
         @(negedge clk);
         if (quiet) check(out_valid == 1'b0, "R9 idle beat produced output", out_valid, 0);
      end
   endtask

   function automatic logic [BUS-1:0] rnd_vec(input int span);
      logic [BUS-1:0] v;
      for (int j = 0; j < LANES; j++) begin
         int x;
         x = int'($urandom_range(2*span-1)) - span;
         v[j*DATA_W +: DATA_W] = 16'(x);
      end
      return v;
   endfunction

   function automatic logic [BUS-1:0] fill(input logic [DATA_W-1:0] x);
      return {LANES{x}};
   endfunction

   // Output monitor: every result is compared in arrival order.
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid === 1'b1 && !done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected output", $signed(out_data), 0);
         end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(int'($signed(out_data)) == e, t, $signed(out_data), e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      in_pix = '0; in_wgt = '0;
      repeat (6) @(negedge clk);
      // R5: quiet during reset
      check(out_valid == 1'b0, "R5 out_valid in reset", out_valid, 0);
      check(out_data == '0, "R5 out_data in reset", out_data, 0);
      rst_n = 1'b1;
      idle(6, 1'b1);
      check(out_data == '0, "R5 out_data after reset", out_data, 0);

      // R4: exact latency and single-cycle pulse; R1 lane placement.
      begin
         logic [BUS-1:0] p, w;
         p = '0; w = '0;
         p[DATA_W +: DATA_W] = 16'h0300;   // lane 1: 3.0
         w[DATA_W +: DATA_W] = 16'h0200;   // lane 1: 2.0
         model_acc = longint'(16'sh0300) * longint'(16'sh0200);
         exp_q.push_back(quant(model_acc)); tag_q.push_back("R1 lane-1 product");
         in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1; in_pix = p; in_wgt = w;
         for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 1) in_valid = 1'b0;
            check(out_valid == (k == LAT), "R4 latency pulse", out_valid, (k == LAT));
         end
         idle(5, 1'b1);
         // R10: result held while idle
         check(int'($signed(out_data)) == 1536, "R10 held result", $signed(out_data), 1536);
      end

      // R6 and R8: sweep residues, one complete output per cycle.
      for (int v = -1024; v < 1024; v++) begin
         logic [BUS-1:0] p, w;
         p = rnd_vec(30000);
         w = '0;
         p[DATA_W-1:0] = 16'(v);
         w[DATA_W-1:0] = 16'h0001;
         beat(1'b1, 1'b1, p, w, "R6/R8 rounding sweep");
      end
      idle(8, 1'b0);

      // R1 and R3: random full-length outputs.
      for (int g = 0; g < 24; g++) begin
         for (int b = 0; b < BEATS; b++)
            beat(b == 0, b == BEATS-1, rnd_vec(600), rnd_vec(80), "R1/R3 random group");
         if (g % 3 == 0) idle(2, 1'b0);
      end
      idle(8, 1'b0);

      // R2: abandoned partial group then a restart.
      for (int b = 0; b < 10; b++) beat(b == 0, 1'b0, rnd_vec(20000), rnd_vec(20000), "R2");
      for (int b = 0; b < BEATS; b++)
         beat(b == 0, b == BEATS-1, rnd_vec(400), rnd_vec(60), "R2 reload on first");
      idle(8, 1'b0);

      // R9: garbage between beats of one group.
      for (int b = 0; b < BEATS; b++) begin
         beat(b == 0, b == BEATS-1, rnd_vec(500), rnd_vec(70), "R9 gaps ignored");
         if (b == 5 || b == 20) idle(3, 1'b1);
      end
      idle(8, 1'b0);

      // R7 and R11: full-scale groups of both signs.
      for (int b = 0; b < BEATS; b++)
         beat(b == 0, b == BEATS-1, fill(16'h8000), fill(16'h8000), "R11/R7 positive full scale");
      for (int b = 0; b < BEATS; b++)
         beat(b == 0, b == BEATS-1, fill(16'h8000), fill(16'h7FFF), "R11/R7 negative full scale");
      for (int b = 0; b < 4; b++)
         beat(b == 0, b == 3, fill(16'h7FFF), fill(16'h7FFF), "R7 short positive clamp");
      idle(10, 1'b0);

      check(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule